// File: doc/BRIEF.md
# Single-Clock 64x36 FIFO with Reset Sequencing and Programmable Almost Flags

This block is a first-in, first-out buffer of 64 words of 36 bits. Writes and reads share one clock. Its control logic sequences the reset and drives four active-low status outputs. Two of the outputs are ready indications: `in_rdy` is low when the buffer is full, and `out_rdy` is low when it is empty. The other two are threshold warnings, `almost_empty_n` and `almost_full_n`. Both warnings compare against one offset, which is captured from a two-bit strap input when reset is released.

The reset input `rst_n` is active low and may change at any time relative to the clock. Assertion takes effect at once. Release passes through a two-stage synchronizer. The controller state machine has three states:
- `ST_HOLD`: in reset. The pointers and the count are cleared, and all flags sit at their reset values.
- `ST_WAIT`: one settling cycle.
- `ST_RUN`: normal operation.

The transitions are:
- *release*: `ST_HOLD` to `ST_WAIT`, on the first clock edge that sees the synchronized reset high. The offset is captured on this edge.
- *arm*: `ST_WAIT` to `ST_RUN`, on the next edge. `in_rdy` rises here.
- *hold*: `ST_RUN` to `ST_RUN`, until reset is asserted again.

Asserting reset sends any state straight back to `ST_HOLD`. The user is expected to hold `rst_n` low for at least four clock edges.

Top module: `sfifo_pflags`

## Requirements
- R1: While `rst_n` is held low, `in_rdy`=0, `out_rdy`=0, `almost_empty_n`=0, `almost_full_n`=1 and `rd_data`=0.
- R2: A falling `rst_n` forces the R1 flag values and an empty count without waiting for a clock edge.
- R3: After `rst_n` rises between clock edges, the outputs keep their R1 values through three rising edges. `in_rdy` goes to 1 on the fourth rising edge: two edges of synchronizer, then two edges of settling. `out_rdy` stays 0.
- R4: On the third rising edge after `rst_n` rises, the offset is loaded as 4*(`ofs_sel`+1), so `ofs_sel` values 0,1,2,3 give 4,8,12,16. Later changes of `ofs_sel` have no effect until the next reset.
- R5: A word is stored on a rising edge only when `wr_en`=1 and `in_rdy`=1. An accepted write raises the stored count by one.
- R6: A read happens on a rising edge only when `rd_en`=1 and `out_rdy`=1. After that edge, `rd_data` holds the oldest stored word, and words leave in the order they were written.
- R7: In operation, `almost_empty_n` is 0 exactly when the stored count is at or below the offset.
- R8: In operation, `almost_full_n` is 0 exactly when the free space (64 minus the count) is at or below the offset.
- R9: A write while `in_rdy`=0 and a read while `out_rdy`=0 are ignored. The count, the flags, the stored order and `rd_data` are unchanged.
- R10: A read and a write accepted on the same edge leave the count and all flags unchanged.
- R11: In operation, `in_rdy` is 0 exactly when the count is 64, and `out_rdy` is 0 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes and reads |
| rst_n | input | 1 | Active-low reset, may be asynchronous |
| ofs_sel | input | 2 | Strap selecting the almost-flag offset, captured at reset release |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word, updated by each accepted read |
| in_rdy | output | 1 | High when a write can be accepted; low when full |
| out_rdy | output | 1 | High when a read can be accepted; low when empty |
| almost_empty_n | output | 1 | Low when the count is at or below the offset |
| almost_full_n | output | 1 | Low when the free space is at or below the offset |

## Verification
The bench builds the block with its default parameters: depth 64, width 36 and an offset step of 4. With these values a complete fill and drain takes about 130 cycles, so every offset selection can be walked from empty to full and back within a short run. At each count the bench compares both threshold flags and both ready flags against the model. This places each almost-flag crossing, at counts of offset and offset+1 near empty and near full, under a check for all four selections. The bench also exercises the blocked write at 64 words, the blocked read at zero words, reset asserted in mid-fill, and a strap change after capture.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } fsm_e;

    // Offset chosen by the strap: step * (code + 1)
    function automatic int sel_to_offset(input int code, input int step);
        return step * (code + 1);
    endfunction

endpackage

// File: rtl/sfifo_rst_sync.sv
`timescale 1ns/1ps
module sfifo_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= 1'b1;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign srst_n = chain_q[STAGES-1];

    // R3: the synchronized release comes only after the earlier stage was high
    assert_sync_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_q[STAGES-1]) |-> $past(chain_q[STAGES-2]));

endmodule

// File: rtl/sfifo_ctrl.sv
`timescale 1ns/1ps
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int SEL_W    = 2,
    parameter int OFS_STEP = 4,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic [SEL_W-1:0] ofs_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_acc,
    output logic             rd_acc,
    output logic [AW-1:0]    wr_ptr,
    output logic [AW-1:0]    rd_ptr,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic             ae_n,
    output logic             af_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fsm_e          st_q, st_d;
    logic [CW-1:0] ofs_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wp_q, rp_q, wp_nxt, rp_nxt;
    logic [CW-1:0] free_cnt;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) st_q <= ST_HOLD;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD: st_d = ST_WAIT;   // release
            ST_WAIT: st_d = ST_RUN;    // arm
            ST_RUN:  st_d = ST_RUN;    // hold
            default: st_d = ST_HOLD;
        endcase
    end

    // ---------------- offset capture ----------------
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)
            ofs_q <= CW'(OFS_STEP);
        else if (st_q == ST_HOLD)
            ofs_q <= CW'(sel_to_offset(int'(ofs_sel), OFS_STEP));
    end

    // ---------------- pointer wrap variant ----------------
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wp_nxt = wp_q + 1'b1;
            assign rp_nxt = rp_q + 1'b1;
        end else begin : g_mod
            assign wp_nxt = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            assign rp_nxt = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
        end
    endgenerate

    assign wr_acc = wr_en && in_rdy;
    assign rd_acc = rd_en && out_rdy;

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_acc) wp_q <= wp_nxt;
            if (rd_acc) rp_q <= rp_nxt;
            if (wr_acc && !rd_acc)      cnt_q <= cnt_q + 1'b1;
            else if (rd_acc && !wr_acc) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign wr_ptr   = wp_q;
    assign rd_ptr   = rp_q;
    assign free_cnt = FULL_CNT - cnt_q;

    // ---------------- flag outputs ----------------
    always_comb begin
        unique case (st_q)
            ST_RUN: begin
                in_rdy  = (cnt_q != FULL_CNT);
                out_rdy = (cnt_q != '0);
                ae_n    = (cnt_q > ofs_q);
                af_n    = (free_cnt > ofs_q);
            end
            default: begin
                in_rdy  = 1'b0;
                out_rdy = 1'b0;
                ae_n    = 1'b0;
                af_n    = 1'b1;
            end
        endcase
    end

    // ---------------- assertions ----------------
    assert_ready_after_wait_R3: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_WAIT) |=> (st_q == ST_RUN && in_rdy));

    assert_offset_hold_R4: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q != ST_HOLD) |=> $stable(ofs_q));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!srst_n)
        (wr_acc && !rd_acc) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!srst_n)
        (cnt_q == FULL_CNT && !rd_en) |=> (cnt_q == FULL_CNT && $stable(wp_q)));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_RUN && cnt_q == '0 && !wr_en) |=> (cnt_q == '0 && $stable(rp_q)));

    assert_pair_keeps_count_R10: assert property (@(posedge clk) disable iff (!srst_n)
        (wr_acc && rd_acc) |=> $stable(cnt_q));

    assert_af_needs_data_R8: assert property (@(posedge clk) disable iff (!srst_n)
        (!af_n) |-> out_rdy);

endmodule

// File: rtl/sfifo_mem.sv
`timescale 1ns/1ps
module sfifo_mem #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             wr_acc,
    input  logic [AW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_acc,
    input  logic [AW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_acc) mem_q[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)     rd_data <= '0;
        else if (rd_acc) rd_data <= mem_q[rd_ptr];
    end

    assert_read_known_R6: assert property (@(posedge clk) disable iff (!srst_n)
        rd_acc |=> !$isunknown(rd_data));

endmodule

// File: rtl/sfifo_pflags.sv
`timescale 1ns/1ps
module sfifo_pflags #(
    parameter int WIDTH    = 36,
    parameter int DEPTH    = 64,
    parameter int SEL_W    = 2,
    parameter int OFS_STEP = 4,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ofs_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic             almost_empty_n,
    output logic             almost_full_n
);

    localparam int AW = $clog2(DEPTH);

    logic          srst_n;
    logic          wr_acc, rd_acc;
    logic [AW-1:0] wr_ptr, rd_ptr;

    sfifo_rst_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_n (srst_n)
    );

    sfifo_ctrl #(.DEPTH(DEPTH), .SEL_W(SEL_W), .OFS_STEP(OFS_STEP)) u_ctrl (
        .clk     (clk),
        .srst_n  (srst_n),
        .ofs_sel (ofs_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .in_rdy  (in_rdy),
        .out_rdy (out_rdy),
        .ae_n    (almost_empty_n),
        .af_n    (almost_full_n)
    );

    sfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .srst_n  (srst_n),
        .wr_acc  (wr_acc),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_acc  (rd_acc),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    // R11: full and empty never shown at once while running
    assert_ready_exclusive_R11: assert property (@(posedge clk) disable iff (!srst_n)
        !(!in_rdy && !out_rdy && almost_full_n == 1'b0));

endmodule

// File: tb/sfifo_pflags_bench.sv
`timescale 1ns/1ps
module sfifo_pflags_bench;

    localparam int DEPTH = 64;
    localparam int WIDTH = 36;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       ofs_sel;
    logic             wr_en, rd_en;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] rd_data;
    logic             in_rdy, out_rdy, almost_empty_n, almost_full_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cnt    = 0;
    int ofs    = 4;
    bit done   = 1'b0;
    bit rd_pend = 1'b0;
    logic [WIDTH-1:0] sb_q [$];
    logic [WIDTH-1:0] mon_exp;
    logic [WIDTH-1:0] last;

    always #10 clk = ~clk;

    sfifo_pflags u_sfifo_pflags (
        .clk(clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .in_rdy(in_rdy), .out_rdy(out_rdy),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    wire [3:0] flags = {in_rdy, out_rdy, almost_empty_n, almost_full_n};

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input int c);
        return {c != DEPTH, c != 0, c > ofs, (DEPTH - c) > ofs};
    endfunction

    // Scoreboard monitor: compare each accepted read against the queue
    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected read", 64'(rd_data), 64'd0);
            end else begin
                mon_exp = sb_q.pop_front();
                check(rd_data === mon_exp, "R6 order", 64'(rd_data), 64'(mon_exp));
            end
        end
        rd_pend = rd_en && out_rdy && rst_n;
    end

    task automatic do_reset(input int s);
        rst_n = 1'b0; ofs_sel = 2'(s); wr_en = 1'b0; rd_en = 1'b0;
        sb_q.delete(); cnt = 0; ofs = 4 * (s + 1);
        #1;
        check(flags == 4'b0001, "R2 immediate reset", 64'(flags), 64'h1);
        repeat (5) begin @(posedge clk); #5; end
        check(flags == 4'b0001, "R1 held flags", 64'(flags), 64'h1);
        check(rd_data == '0, "R1 rd_data", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        for (int e = 1; e <= 4; e++) begin
            @(posedge clk); #5;
            if (e < 4) check(flags == 4'b0001, "R3 still held", 64'(flags), 64'h1);
            else       check(flags == exp_flags(0), "R3 in_rdy rises", 64'(flags), 64'(exp_flags(0)));
        end
    endtask

    task automatic op(input bit w, input bit r, input logic [WIDTH-1:0] d, input string req);
        bit aw, ar;
        aw = w && (cnt < DEPTH);
        ar = r && (cnt > 0);
        wr_en = w; rd_en = r; wr_data = d;
        if (aw) sb_q.push_back(d);
        cnt = cnt + int'(aw) - int'(ar);
        @(posedge clk); #5;
        wr_en = 1'b0; rd_en = 1'b0;
        check(flags == exp_flags(cnt), req, 64'(flags), 64'(exp_flags(cnt)));
    endtask

    function automatic logic [WIDTH-1:0] word(input int s, input int i);
        return {4'(s), 32'h1234_0000 ^ 32'(i * 40503)};
    endfunction

    initial begin
        rst_n = 1'b0; ofs_sel = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        for (int s = 0; s < 4; s++) begin
            do_reset(s);
            for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, word(s, i), "R5 R7 R8 R11 fill");
            op(1'b1, 1'b0, 36'hBAD_BAD_BAD, "R9 write when full");
            check(sb_q.size() == DEPTH, "R9 queue at full", 64'(sb_q.size()), 64'(DEPTH));
            op(1'b1, 1'b1, 36'hDEAD_0000, "R5 R11 read+write at full");
            op(1'b1, 1'b0, word(s, 100), "R5 refill");
            for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, '0, "R6 R7 R8 R11 drain");
            @(negedge clk); #2;
            last = rd_data;
            op(1'b0, 1'b1, '0, "R9 read when empty");
            #6;
            check(rd_data == last, "R9 rd_data held", 64'(rd_data), 64'(last));
            @(posedge clk); #5;
        end

        // Strap change after capture must not move the thresholds
        do_reset(0);
        ofs_sel = 2'd3;
        for (int i = 0; i < 10; i++) op(1'b1, 1'b0, word(5, i), "R4 offset kept");
        op(1'b1, 1'b1, word(5, 10), "R10 simultaneous");
        op(1'b1, 1'b1, word(5, 11), "R10 simultaneous again");
        for (int i = 0; i < 3; i++) op(1'b0, 1'b1, '0, "R6 partial drain");

        // Reset asserted mid-run takes effect with no clock edge
        @(negedge clk); #2;
        rst_n = 1'b0;
        sb_q.delete(); cnt = 0;
        #1;
        check(flags == 4'b0001, "R2 mid-run reset", 64'(flags), 64'h1);
        @(posedge clk); #5;
        check(flags == 4'b0001, "R1 after mid-run reset", 64'(flags), 64'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule